// File: doc/BRIEF.md
# Burst Low-Address Sequencer

This block produces the two lowest address bits for a four-beat burst access in a synchronous pipelined memory. When an access begins, the controller pulses the load input together with the low two bits of the access address. On each later clock edge where the active-low advance input is low, the block steps to the next position of the burst. The output is joined with the registered upper address bits outside the block. The same sequencing serves read bursts and write bursts.

Two orderings are supported. Linear order counts upward from the start value and wraps modulo four. Interleaved order XORs the start value with the beat index. The ordering input is captured when a burst is loaded, so the ordering stays fixed for the whole burst. The output is registered and reflects the state that holds after each clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, `addr_o` is 0 after that edge, and the internal beat index is cleared.
- R2: When `load_i` is high at a clock edge, `addr_o` equals the value of `start_i` from that edge, starting in the cycle right after it.
- R3: When `load_i` is low and `adv_n_i` is low at a clock edge, the burst moves exactly one position forward in its sequence.
- R4: When `load_i` is low and `adv_n_i` is high at a clock edge, `addr_o` keeps its value.
- R5: In linear order, after k advances since the load, `addr_o` = (start + k) mod 4. For example, start 2 gives 2,3,0,1.
- R6: In interleaved order, after k advances since the load, `addr_o` = start XOR (k mod 4). For example, start 1 gives 1,0,3,2.
- R7: `order_i` is sampled only on a load edge, with 0 meaning linear and 1 meaning interleaved. Changing it while no load is applied does not change `addr_o`.
- R8: If `load_i` and `adv_n_i` are both active at the same edge, the load wins: `addr_o` becomes `start_i` and the beat index restarts at 0.
- R9: After four advances following a load, `addr_o` returns to the start value in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Begins a burst and captures `start_i` and `order_i` |
| adv_n_i | input | 1 | Advance, active low |
| order_i | input | 1 | Burst order: 0 selects linear, 1 selects interleaved |
| start_i | input | 2 | Low address bits of the first beat |
| addr_o | output | 2 | Registered low address bits of the current beat |

## Verification
The assertions check on every cycle that reset clears the output and that a load makes the output equal to the captured start value. They also check that an idle edge holds the output, that the beat index clears on a load and steps by one on an advance, and that in linear order each advance adds one to the output. The bench scenarios are needed to show the full interleaved sequences, the return to the start value after four beats, that `order_i` is ignored between loads, and that a load wins over a simultaneous advance.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] beat_nxt_o,
  output logic [W-1:0] beat_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] beat_q;

  always_comb begin
    if (load_i)      beat_nxt_o = '0;
    else if (step_i) beat_nxt_o = beat_q + ONE;
    else             beat_nxt_o = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt_o;
  end

  assign beat_o = beat_q;

  // R8
  beat_clear_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (beat_o == '0));

  // R3
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i) |=> (beat_o == $past(beat_o) + ONE));

  // R1
  beat_reset_chk: assert property (@(posedge clk)
    rst |=> (beat_o == '0));
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
  import burst_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] start_i,
  input  logic [W-1:0] beat_i,
  input  order_e       order_i,
  output logic [W-1:0] addr_o
);
  logic [W-1:0] lin_addr;
  logic [W-1:0] xor_addr;
  logic [W:0]   carry;

  assign carry[0] = 1'b0;

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign xor_addr[b]  = start_i[b] ^ beat_i[b];
      assign lin_addr[b]  = start_i[b] ^ beat_i[b] ^ carry[b];
      assign carry[b+1]   = (start_i[b] & beat_i[b]) |
                            (carry[b] & (start_i[b] ^ beat_i[b]));
    end
  endgenerate

  assign addr_o = (order_i == ORDER_XOR) ? xor_addr : lin_addr;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_seq_pkg::*;
#(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         adv_n_i,
  input  logic         order_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] addr_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] start_q, start_nxt;
  order_e       order_q, order_nxt;
  logic [W-1:0] beat_nxt, beat_cur;
  logic [W-1:0] addr_nxt, addr_q;

  always_comb begin
    start_nxt = load_i ? start_i : start_q;
    order_nxt = load_i ? order_e'(order_i) : order_q;
  end

  burst_beat_ctr #(.W(W)) u_beat (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .step_i     (!adv_n_i),
    .beat_nxt_o (beat_nxt),
    .beat_o     (beat_cur)
  );

  burst_seq_map #(.W(W)) u_map (
    .start_i (start_nxt),
    .beat_i  (beat_nxt),
    .order_i (order_nxt),
    .addr_o  (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      order_q <= ORDER_LINEAR;
      addr_q  <= '0;
    end else begin
      start_q <= start_nxt;
      order_q <= order_nxt;
      addr_q  <= addr_nxt;
    end
  end

  assign addr_o = addr_q;

  // R1
  addr_reset_chk: assert property (@(posedge clk)
    rst |=> (addr_o == '0));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (addr_o == $past(start_i)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && adv_n_i) |=> $stable(addr_o));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !adv_n_i && order_q == ORDER_LINEAR) |=>
      (addr_o == $past(addr_o) + ONE));

  // R9
  wrap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_cur == '0) |-> (addr_o == start_q));
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_i = 1'b0;
  logic       adv_n_i = 1'b1;
  logic       order_i = 1'b0;
  logic [1:0] start_i = 2'd0;
  logic [1:0] addr_o;

  int n_run = 0;
  int n_fail = 0;

  logic [1:0] m_start = 2'd0;
  logic [1:0] m_beat = 2'd0;
  logic       m_order = 1'b0;

  always #4 clk = ~clk;

  burst_addr_gen #(.W(2)) dut (
    .clk(clk), .rst(rst), .load_i(load_i), .adv_n_i(adv_n_i),
    .order_i(order_i), .start_i(start_i), .addr_o(addr_o)
  );

  function automatic logic [1:0] exp_addr(input logic [1:0] s, input logic [1:0] k,
                                          input logic ord);
    return ord ? (s ^ k) : (s + k);
  endfunction

  task automatic check(input string req, input logic [1:0] exp);
    n_run++;
    if (addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%0d expected=%0d", req, addr_o, exp);
    end
  endtask

  task automatic step(input logic ld, input logic advn, input logic ord,
                      input logic [1:0] s, input string req);
    @(negedge clk);
    load_i = ld; adv_n_i = advn; order_i = ord; start_i = s;
    @(posedge clk);
    if (ld) begin
      m_start = s; m_order = ord; m_beat = 2'd0;
    end else if (!advn) begin
      m_beat = m_beat + 2'd1;
    end
    #1;
    check(req, exp_addr(m_start, m_beat, m_order));
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", 2'd0);
    @(negedge clk); rst = 1'b0;

    // R5 linear from 2: 2,3,0,1 then R9 back to 2
    step(1, 1, 0, 2'd2, "R2");
    if (addr_o !== 2'd2) begin end
    step(0, 0, 0, 2'd0, "R5");
    check("R5", 2'd3);
    step(0, 0, 0, 2'd0, "R5");
    check("R5", 2'd0);
    step(0, 0, 0, 2'd0, "R5");
    check("R5", 2'd1);
    step(0, 0, 0, 2'd0, "R9");
    check("R9", 2'd2);

    // R6 interleaved from 1: 1,0,3,2 then R9 back to 1
    step(1, 1, 1, 2'd1, "R2");
    check("R2", 2'd1);
    step(0, 0, 1, 2'd0, "R6");
    check("R6", 2'd0);
    step(0, 0, 1, 2'd0, "R6");
    check("R6", 2'd3);
    step(0, 0, 1, 2'd0, "R6");
    check("R6", 2'd2);
    step(0, 0, 1, 2'd0, "R9");
    check("R9", 2'd1);

    // R4 hold
    step(0, 1, 1, 2'd3, "R4");
    check("R4", 2'd1);
    step(0, 1, 0, 2'd2, "R4");
    check("R4", 2'd1);

    // R7: order change between loads ignored (burst is interleaved from 1, beat 0)
    step(0, 0, 0, 2'd0, "R7");
    check("R7", 2'd0);
    step(0, 0, 0, 2'd0, "R7");
    check("R7", 2'd3);

    // R8: load with advance restarts
    step(1, 0, 0, 2'd3, "R8");
    check("R8", 2'd3);
    step(0, 0, 0, 2'd0, "R3");
    check("R3", 2'd0);

    // R6 interleaved from 2: 2,3,0,1
    step(1, 1, 1, 2'd2, "R2");
    step(0, 0, 1, 2'd0, "R6");
    check("R6", 2'd3);
    step(0, 0, 1, 2'd0, "R6");
    check("R6", 2'd0);

    // R1: reset mid-burst
    @(negedge clk); rst = 1'b1; load_i = 1'b0; adv_n_i = 1'b1;
    @(posedge clk); #1;
    m_start = 2'd0; m_beat = 2'd0; m_order = 1'b0;
    check("R1", 2'd0);
    @(negedge clk); rst = 1'b0;
    step(0, 0, 0, 2'd0, "R1");
    check("R1", 2'd1);

    // random mix
    void'($urandom(32'd4242));
    for (int i = 0; i < 3000; i++) begin
      logic ld, advn, ord;
      logic [1:0] s;
      ld   = ($urandom % 5) == 0;
      advn = ($urandom % 3) == 0;
      ord  = $urandom % 2;
      s    = $urandom % 4;
      step(ld, advn, ord, s, "R3");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule